// File: doc/BRIEF.md
# Keyboard controller command decoder

This block is the host-facing register front end of a PC-style keyboard controller. A byte-wide bus reaches two ports, chosen by one select bit: the command/status port and the data port. Bytes written to the command port are decoded as controller commands. Some commands act at once: they change mode bits, set the self-test flag or queue a fixed reply. Others only arm a latch, and that latch decides where the next data-port byte goes. Reading the command port returns a status byte. Reading the data port pops the oldest pending reply.

Replies wait in two 16-byte queues, one for the keyboard side and one for the auxiliary side. Plain data bytes, mouse-directed bytes and output-port writes go to neighbouring blocks as one-cycle strobes. Those neighbours handle the serial device protocols, the scan-code translation and the output-port logic. The block drives the two interrupt lines and the translation enable. It also flags command bytes it does not support and replies that are dropped because a queue is full.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset, the status byte reads 0x18, the mode register holds 0x03, both interrupts are low, the translation enable is low and no strobe is active.
- R2: Command 0x20 pushes the current mode register value into the keyboard-side reply queue.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a latch. The next data-port write then goes to one target, chosen by the armed command:
  - 0x60: the mode register.
  - 0xD1: the output-port write strobe.
  - 0xD2: the keyboard reply queue.
  - 0xD3: the auxiliary reply queue.
  - 0xD4: the mouse byte strobe.
  
  Any data-port write clears the latch. With no latch armed, a data byte is sent out on the keyboard byte strobe one cycle after the write.
- R4: Command 0xAA sets status bit 2 and queues 0x55. Commands 0xA9, 0xAB and 0xC0 each queue 0x00.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R6: The translation enable output follows mode bit 6.
- R7: Command 0xD0 queues the value present on the output-port input.
- R8: Any other command byte raises the unsupported flag for one cycle. It leaves the mode register, the armed latch and both reply queues unchanged.
- R9: Each reply queue holds 16 bytes in order. A push into a full queue is dropped, and the overflow flag pulses for one cycle.
- R10: A data-port read returns the keyboard-queue head when that queue is not empty. Otherwise it returns the auxiliary head. Status bit 0 is set while either queue holds a byte. Status bit 5 is set only when the auxiliary head is the one presented.
- R11: The keyboard interrupt is high when the keyboard queue is not empty, mode bit 0 is set and mode bit 4 is clear. The auxiliary interrupt is high when the auxiliary head is presented and mode bit 1 is set.
- R12: Status bit 3 is set by a command-port write and cleared by a data-port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data-port read pops a reply |
| bus_sel | input | 1 | 1 = command/status port, 0 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (status or reply head) |
| outport_val | input | 8 | Current output-port value from the neighbouring block |
| kbd_byte_stb | output | 1 | Plain data byte for the keyboard device |
| kbd_byte | output | 8 | Byte carried with kbd_byte_stb |
| mouse_byte_stb | output | 1 | Byte directed to the mouse device |
| mouse_byte | output | 8 | Byte carried with mouse_byte_stb |
| outport_wr_stb | output | 1 | Output-port write request |
| outport_wdata | output | 8 | Byte carried with outport_wr_stb |
| xlate_en | output | 1 | Scan-code translation enable |
| irq_kbd | output | 1 | Keyboard-side interrupt |
| irq_aux | output | 1 | Auxiliary-side interrupt |
| unsup_cmd | output | 1 | One-cycle flag for an unsupported command |
| fifo_ovf | output | 1 | One-cycle flag for a dropped reply |

## Verification
The unarmed data path is tried with all 256 byte values, which separates correct forwarding from a stuck or swapped bit. The mode register is written and read back for all 256 values. This shows that every bit is stored, that bit 6 alone drives translation, and that the keyboard interrupt follows only bits 0 and 4. All 256 command codes are swept. The unsupported ones are written while a latch is armed, which shows whether a bad byte disturbs the latch, the mode or the queues. The dual-queue cases separate the read priority from arrival order. A 17-push run separates the queue's storage limit from its drop reporting.

// File: rtl/kbc_pkg.sv
`timescale 1ns/1ps
package kbc_pkg;

   localparam logic [7:0] CMD_RD_MODE   = 8'h20;
   localparam logic [7:0] CMD_WR_MODE   = 8'h60;
   localparam logic [7:0] CMD_AUX_OFF   = 8'hA7;
   localparam logic [7:0] CMD_AUX_ON    = 8'hA8;
   localparam logic [7:0] CMD_AUX_TEST  = 8'hA9;
   localparam logic [7:0] CMD_SELF_TEST = 8'hAA;
   localparam logic [7:0] CMD_KBD_TEST  = 8'hAB;
   localparam logic [7:0] CMD_KBD_OFF   = 8'hAD;
   localparam logic [7:0] CMD_KBD_ON    = 8'hAE;
   localparam logic [7:0] CMD_RD_INPUT  = 8'hC0;
   localparam logic [7:0] CMD_RD_OUTP   = 8'hD0;
   localparam logic [7:0] CMD_WR_OUTP   = 8'hD1;
   localparam logic [7:0] CMD_WR_KBUF   = 8'hD2;
   localparam logic [7:0] CMD_WR_ABUF   = 8'hD3;
   localparam logic [7:0] CMD_WR_MOUSE  = 8'hD4;

   localparam int MB_KIRQ = 0;
   localparam int MB_AIRQ = 1;
   localparam int MB_KDIS = 4;
   localparam int MB_ADIS = 5;
   localparam int MB_XLAT = 6;

   localparam int SB_OBF  = 0;
   localparam int SB_SELF = 2;
   localparam int SB_CMD  = 3;
   localparam int SB_UNLK = 4;
   localparam int SB_AOBF = 5;

   localparam logic [7:0] MODE_RST  = 8'h03;
   localparam logic [7:0] PASS_BYTE = 8'h55;

   typedef enum logic [2:0] {
      LAT_NONE, LAT_MODE, LAT_OUTP, LAT_KBUF, LAT_ABUF, LAT_MOUSE
   } latch_e;

   typedef enum logic [2:0] {
      RPL_NONE, RPL_MODE, RPL_OUTP, RPL_ZERO, RPL_PASS
   } reply_e;

   typedef struct packed {
      latch_e     latch;
      reply_e     reply;
      logic       selftest;
      logic [7:0] mode_set;
      logic [7:0] mode_clr;
      logic       unsup;
   } cmd_dec_t;

endpackage

// File: rtl/kbc_reply_fifo.sv
`timescale 1ns/1ps
module kbc_reply_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          drop
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("kbc_reply_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          full, acc, do_pop;

   assign empty  = (cnt == '0);
   assign full   = (cnt == FULL_CNT);
   assign do_pop = pop & ~empty;
   assign acc    = push & (~full | do_pop);
   assign drop   = push & ~acc;
   assign head   = mem[rp];

   always_ff @(posedge clk) begin
      if (acc) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (acc)    wp <= wp + 1'b1;
         if (do_pop) rp <= rp + 1'b1;
         case ({acc, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);
   assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == FULL_CNT));

endmodule

// File: rtl/kbc_cmd_decode.sv
`timescale 1ns/1ps
module kbc_cmd_decode
   import kbc_pkg::*;
(
   input  logic [7:0] code,
   output cmd_dec_t   dec
);
   always_comb begin
      dec          = '0;
      dec.latch    = LAT_NONE;
      dec.reply    = RPL_NONE;
      case (code)
         CMD_RD_MODE:   dec.reply = RPL_MODE;
         CMD_WR_MODE:   dec.latch = LAT_MODE;
         CMD_WR_OUTP:   dec.latch = LAT_OUTP;
         CMD_WR_KBUF:   dec.latch = LAT_KBUF;
         CMD_WR_ABUF:   dec.latch = LAT_ABUF;
         CMD_WR_MOUSE:  dec.latch = LAT_MOUSE;
         CMD_AUX_OFF:   dec.mode_set[MB_ADIS] = 1'b1;
         CMD_AUX_ON:    dec.mode_clr[MB_ADIS] = 1'b1;
         CMD_KBD_OFF:   dec.mode_set[MB_KDIS] = 1'b1;
         CMD_KBD_ON:    dec.mode_clr[MB_KDIS] = 1'b1;
         CMD_SELF_TEST: begin
            dec.selftest = 1'b1;
            dec.reply    = RPL_PASS;
         end
         CMD_AUX_TEST, CMD_KBD_TEST, CMD_RD_INPUT: dec.reply = RPL_ZERO;
         CMD_RD_OUTP:   dec.reply = RPL_OUTP;
         default:       dec.unsup = 1'b1;
      endcase
   end
endmodule

// File: rtl/kbc_cmd_decoder.sv
`timescale 1ns/1ps
module kbc_cmd_decoder
   import kbc_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_sel,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [BYTE_W-1:0] outport_val,
   output logic              kbd_byte_stb,
   output logic [BYTE_W-1:0] kbd_byte,
   output logic              mouse_byte_stb,
   output logic [BYTE_W-1:0] mouse_byte,
   output logic              outport_wr_stb,
   output logic [BYTE_W-1:0] outport_wdata,
   output logic              xlate_en,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              unsup_cmd,
   output logic              fifo_ovf
);
   localparam int NCH    = 2;
   localparam int CH_KBD = 0;
   localparam int CH_AUX = 1;

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("kbc_cmd_decoder: command codes are bytes, BYTE_W must be 8");
      end
   endgenerate

   cmd_dec_t          dec;
   latch_e            latch_r;
   logic [7:0]        mode_r;
   logic              selftest_r, cmdflag_r;
   logic              cmd_wr, dat_wr, dat_rd;
   logic [7:0]        reply_val;
   logic [7:0]        status_w;
   logic [NCH-1:0]    f_push, f_pop, f_empty, f_drop;
   logic [BYTE_W-1:0] f_din  [NCH];
   logic [BYTE_W-1:0] f_head [NCH];

   assign cmd_wr = bus_wr &  bus_sel;
   assign dat_wr = bus_wr & ~bus_sel;
   assign dat_rd = bus_rd & ~bus_sel;

   kbc_cmd_decode u_dec (.code(bus_wdata), .dec(dec));

   always_comb begin
      case (dec.reply)
         RPL_MODE: reply_val = mode_r;
         RPL_OUTP: reply_val = outport_val;
         RPL_PASS: reply_val = PASS_BYTE;
         default:  reply_val = 8'h00;
      endcase
   end

   assign f_push[CH_KBD] = (cmd_wr && dec.reply != RPL_NONE) ||
                           (dat_wr && latch_r == LAT_KBUF);
   assign f_din[CH_KBD]  = cmd_wr ? reply_val : bus_wdata;
   assign f_push[CH_AUX] = dat_wr && latch_r == LAT_ABUF;
   assign f_din[CH_AUX]  = bus_wdata;
   assign f_pop[CH_KBD]  = dat_rd & ~f_empty[CH_KBD];
   assign f_pop[CH_AUX]  = dat_rd &  f_empty[CH_KBD] & ~f_empty[CH_AUX];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         kbc_reply_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (f_push[c]),
            .din   (f_din[c]),
            .pop   (f_pop[c]),
            .head  (f_head[c]),
            .empty (f_empty[c]),
            .drop  (f_drop[c])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_r     <= MODE_RST;
         latch_r    <= LAT_NONE;
         selftest_r <= 1'b0;
         cmdflag_r  <= 1'b1;
      end else if (cmd_wr) begin
         mode_r    <= (mode_r | dec.mode_set) & ~dec.mode_clr;
         cmdflag_r <= 1'b1;
         if (dec.latch != LAT_NONE) latch_r <= dec.latch;
         if (dec.selftest) selftest_r <= 1'b1;
      end else if (dat_wr) begin
         cmdflag_r <= 1'b0;
         latch_r   <= LAT_NONE;
         if (latch_r == LAT_MODE) mode_r <= bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kbd_byte_stb   <= 1'b0;
         mouse_byte_stb <= 1'b0;
         outport_wr_stb <= 1'b0;
         unsup_cmd      <= 1'b0;
         fifo_ovf       <= 1'b0;
         kbd_byte       <= '0;
         mouse_byte     <= '0;
         outport_wdata  <= '0;
      end else begin
         kbd_byte_stb   <= dat_wr && latch_r == LAT_NONE;
         mouse_byte_stb <= dat_wr && latch_r == LAT_MOUSE;
         outport_wr_stb <= dat_wr && latch_r == LAT_OUTP;
         unsup_cmd      <= cmd_wr && dec.unsup;
         fifo_ovf       <= |f_drop;
         if (dat_wr) begin
            kbd_byte      <= bus_wdata;
            mouse_byte    <= bus_wdata;
            outport_wdata <= bus_wdata;
         end
      end
   end

   always_comb begin
      status_w          = '0;
      status_w[SB_OBF]  = ~(&f_empty);
      status_w[SB_SELF] = selftest_r;
      status_w[SB_CMD]  = cmdflag_r;
      status_w[SB_UNLK] = 1'b1;
      status_w[SB_AOBF] = f_empty[CH_KBD] & ~f_empty[CH_AUX];
   end

   always_comb begin
      if (bus_sel)                bus_rdata = status_w;
      else if (!f_empty[CH_KBD])  bus_rdata = f_head[CH_KBD];
      else if (!f_empty[CH_AUX])  bus_rdata = f_head[CH_AUX];
      else                        bus_rdata = '0;
   end

   assign xlate_en = mode_r[MB_XLAT];
   assign irq_kbd  = ~f_empty[CH_KBD] & mode_r[MB_KIRQ] & ~mode_r[MB_KDIS];
   assign irq_aux  = status_w[SB_AOBF] & mode_r[MB_AIRQ];

   assert_latch_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> (latch_r == LAT_NONE));
   assert_unsup_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_cmd |-> $past(cmd_wr));
   assert_unsup_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.unsup) |=> $stable(mode_r));
   assert_unsup_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.unsup) |=> $stable(latch_r));
   assert_irq_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd && irq_aux));
   assert_cmdflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> !status_w[SB_CMD]);

endmodule

// File: tb/sim_kbc_cmd_decoder.sv
`timescale 1ns/1ps
module sim_kbc_cmd_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
   logic [7:0] bus_wdata = 8'h00, outport_val = 8'hA5;
   logic [7:0] bus_rdata, kbd_byte, mouse_byte, outport_wdata;
   logic kbd_byte_stb, mouse_byte_stb, outport_wr_stb, xlate_en;
   logic irq_kbd, irq_aux, unsup_cmd, fifo_ovf;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   kbc_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .outport_val(outport_val), .kbd_byte_stb(kbd_byte_stb),
      .kbd_byte(kbd_byte), .mouse_byte_stb(mouse_byte_stb),
      .mouse_byte(mouse_byte), .outport_wr_stb(outport_wr_stb),
      .outport_wdata(outport_wdata), .xlate_en(xlate_en),
      .irq_kbd(irq_kbd), .irq_aux(irq_aux), .unsup_cmd(unsup_cmd),
      .fifo_ovf(fifo_ovf));

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [7:0] b);
      @(negedge clk); bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = b;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic wr_dat(input logic [7:0] b);
      @(negedge clk); bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = b;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_dat(output logic [7:0] v);
      @(negedge clk); bus_rd = 1'b1; bus_sel = 1'b0;
      #1 v = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic rd_stat(output logic [7:0] v);
      @(negedge clk); bus_sel = 1'b1;
      #1 v = bus_rdata;
   endtask

   function automatic bit known_cmd(input logic [7:0] c);
      case (c)
         8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
         8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_stat(s);
      chk("R1", "status", s, 8'h18);
      chk("R1", "irq/xlate/stb", {irq_kbd, irq_aux, xlate_en, kbd_byte_stb,
          mouse_byte_stb, outport_wr_stb, unsup_cmd, fifo_ovf}, 8'h00);
      wr_cmd(8'h20);
      chk("R11", "irq_kbd with mode 03 reply", {7'd0, irq_kbd}, 8'h01);
      rd_stat(s);
      chk("R10", "status obf", s, 8'h19);
      rd_dat(v);
      chk("R2", "reset mode readback", v, 8'h03);

      // R3 unarmed data sweep
      for (int i = 0; i < 256; i++) begin
         wr_dat(8'(i));
         chk("R3", "plain kbd strobe", {7'd0, kbd_byte_stb}, 8'h01);
         chk("R3", "plain kbd byte", kbd_byte, 8'(i));
         chk("R3", "no mouse/outport strobe",
             {6'd0, mouse_byte_stb, outport_wr_stb}, 8'h00);
      end
      rd_stat(s);
      chk("R12", "data write clears cmd bit", s, 8'h10);

      // R3 R6 R11 mode sweep
      for (int i = 0; i < 256; i++) begin
         wr_cmd(8'h60);
         wr_dat(8'(i));
         chk("R3", "mode write not forwarded", {7'd0, kbd_byte_stb}, 8'h00);
         chk("R6", "xlate_en", {7'd0, xlate_en}, {7'd0, i[6]});
         wr_cmd(8'h20);
         chk("R11", "irq_kbd", {7'd0, irq_kbd}, {7'd0, i[0] & ~i[4]});
         chk("R11", "irq_aux idle", {7'd0, irq_aux}, 8'h00);
         rd_dat(v);
         chk("R3", "mode readback", v, 8'(i));
      end
      wr_cmd(8'h60); wr_dat(8'h03);

      // R3 latch clears after one data write
      wr_cmd(8'h60); wr_dat(8'h03);
      wr_dat(8'h3C);
      chk("R3", "latch cleared", {7'd0, kbd_byte_stb}, 8'h01);

      // R3 output port and mouse routes
      wr_cmd(8'hD1); wr_dat(8'h9E);
      chk("R3", "outport strobe", {7'd0, outport_wr_stb}, 8'h01);
      chk("R3", "outport byte", outport_wdata, 8'h9E);
      chk("R3", "outport no kbd", {7'd0, kbd_byte_stb}, 8'h00);
      wr_cmd(8'hD4); wr_dat(8'h6B);
      chk("R3", "mouse strobe", {7'd0, mouse_byte_stb}, 8'h01);
      chk("R3", "mouse byte", mouse_byte, 8'h6B);

      // R3 R10 R11 aux buffer
      wr_cmd(8'hD3); wr_dat(8'h47);
      rd_stat(s);
      chk("R10", "aux pending status", s, 8'h31);
      chk("R11", "irq_aux/irq_kbd", {6'd0, irq_aux, irq_kbd}, 8'h02);
      rd_dat(v);
      chk("R3", "aux byte", v, 8'h47);
      rd_stat(s);
      chk("R10", "drained status", s, 8'h10);

      // R10 priority
      wr_cmd(8'hD3); wr_dat(8'h81);
      wr_cmd(8'hD2); wr_dat(8'h82);
      rd_stat(s);
      chk("R10", "kbd masks aux bit", s, 8'h11);
      chk("R11", "kbd irq only", {6'd0, irq_aux, irq_kbd}, 8'h01);
      rd_dat(v);
      chk("R10", "kbd first", v, 8'h82);
      rd_stat(s);
      chk("R10", "aux now presented", s, 8'h31);
      rd_dat(v);
      chk("R10", "aux second", v, 8'h81);

      // R4 canned replies
      wr_cmd(8'hAA);
      rd_stat(s);
      chk("R4", "selftest bit", s, 8'h1D);
      rd_dat(v); chk("R4", "self test reply", v, 8'h55);
      wr_cmd(8'hA9); wr_cmd(8'hAB); wr_cmd(8'hC0);
      rd_dat(v); chk("R4", "A9 reply", v, 8'h00);
      rd_dat(v); chk("R4", "AB reply", v, 8'h00);
      rd_dat(v); chk("R4", "C0 reply", v, 8'h00);
      rd_stat(s);
      chk("R4", "three replies drained", s, 8'h1C);

      // R5 disable bits
      wr_cmd(8'hA7); wr_cmd(8'h20); rd_dat(v);
      chk("R5", "A7 sets bit5", v, 8'h23);
      wr_cmd(8'hA8); wr_cmd(8'h20); rd_dat(v);
      chk("R5", "A8 clears bit5", v, 8'h03);
      wr_cmd(8'hAD); wr_cmd(8'h20);
      chk("R5", "kbd disabled masks irq", {7'd0, irq_kbd}, 8'h00);
      rd_dat(v);
      chk("R5", "AD sets bit4", v, 8'h13);
      wr_cmd(8'hAE); wr_cmd(8'h20); rd_dat(v);
      chk("R5", "AE clears bit4", v, 8'h03);

      // R7 output port readback
      outport_val = 8'hA5;
      wr_cmd(8'hD0); rd_dat(v);
      chk("R7", "outport A5", v, 8'hA5);
      outport_val = 8'h5A;
      wr_cmd(8'hD0); rd_dat(v);
      chk("R7", "outport 5A", v, 8'h5A);

      // R8 unsupported sweep with latch armed
      wr_cmd(8'hD2);
      for (int i = 0; i < 256; i++) begin
         if (!known_cmd(8'(i))) begin
            wr_cmd(8'(i));
            chk("R8", "unsup flag", {7'd0, unsup_cmd}, 8'h01);
            rd_stat(s);
            chk("R8", "no reply queued", s & 8'h21, 8'h00);
         end
      end
      @(negedge clk);
      chk("R8", "flag one cycle", {7'd0, unsup_cmd}, 8'h00);
      wr_dat(8'h77);
      chk("R8", "latch kept (no kbd strobe)", {7'd0, kbd_byte_stb}, 8'h00);
      rd_dat(v);
      chk("R8", "latched route kept", v, 8'h77);
      wr_cmd(8'h20);
      chk("R8", "known cmd no flag", {7'd0, unsup_cmd}, 8'h00);
      rd_dat(v);
      chk("R8", "mode unchanged", v, 8'h03);

      // R9 overflow
      for (int i = 0; i < 16; i++) begin
         wr_cmd(8'hD2); wr_dat(8'(8'hC0 + i));
         chk("R9", "no drop below depth", {7'd0, fifo_ovf}, 8'h00);
      end
      wr_cmd(8'hD2); wr_dat(8'hEE);
      chk("R9", "drop flagged", {7'd0, fifo_ovf}, 8'h01);
      @(negedge clk);
      chk("R9", "drop flag one cycle", {7'd0, fifo_ovf}, 8'h00);
      for (int i = 0; i < 16; i++) begin
         rd_dat(v);
         chk("R9", "order", v, 8'(8'hC0 + i));
      end
      rd_stat(s);
      chk("R9", "dropped byte absent", s & 8'h21, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule